// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block connects four level-sensitive PCI interrupt lines to a sixteen-input legacy interrupt controller. It has two independent parts. A combinational swizzle takes a device/function number and an interrupt pin and returns the bridge interrupt line that the pin drives. Three on-board slots have fixed wiring. Four expansion slots rotate the pin by their slot position. Every other slot passes the pin through unchanged.

The second part is a router. It holds one 8-bit route register per PCI line, loaded through an index/data/write-enable port. Each controller input is driven by the OR of the current levels of all PCI lines whose route register names that input. A route value at or above the number of controller inputs parks its line, so the line drives nothing. Levels pass to the outputs combinationally. A register write takes effect from the clock edge that captures it.

Top module: `irq_route_top`

## Requirements
- R1: The slot number is `swz_devfn[7:3]`. Slot 10 yields line 3 for every pin.
- R2: Slots 11 and 12 yield line 0 for every pin.
- R3: Slots 18, 19, 20 and 21 yield `(slot - 18 + pin) mod 4`.
- R4: Any slot other than 10, 11, 12 and 18 to 21 yields the pin number unchanged.
- R5: Reset loads 0x80 into every route register. After reset, `pic_lvl` stays all zero whatever the PCI line levels are.
- R6: A rising clock edge with `cfg_we` high stores `cfg_data` into the route register of line `cfg_idx`. `pic_lvl` reflects the new route after that edge and not before it.
- R7: A route value of 16 or more disables its line. This includes 16 and 255. The disabled line sets no bit of `pic_lvl`.
- R8: Bit n of `pic_lvl` is the OR of `pci_lvl[k]` over every line k whose route register equals n. This covers several lines sharing one output.
- R9: A change on `pci_lvl` appears on `pic_lvl` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the route registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| swz_devfn | input | 8 | Device/function number for the swizzle query |
| swz_pin | input | 2 | Interrupt pin for the swizzle query (0 to 3) |
| swz_line | output | 2 | Bridge interrupt line returned by the swizzle |
| cfg_we | input | 1 | Write enable for a route register |
| cfg_idx | input | 2 | PCI line whose route register is written |
| cfg_data | input | 8 | Route value to store |
| pci_lvl | input | 4 | Current levels of the four PCI interrupt lines |
| pic_lvl | output | 16 | Levels driven to the interrupt controller inputs |

## Verification
The swizzle answer and the effect of a line-level change are due with no clock edge at all. The bench therefore samples them one time unit after driving the inputs, while the routes in force are still the old ones. A route write is due only after the rising edge that captures it. The bench commits the write to its own route model after the same-cycle check and compares `pic_lvl` at the next falling edge. In that way every expected value is formed from exactly the register state the design holds at that moment.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int unsigned PCI_LINES  = 4;
   localparam int unsigned PIC_INPUTS = 16;
   localparam int unsigned ROUTE_BITS = 8;
   localparam int unsigned SLOT_BITS  = 5;
   localparam int unsigned FUNC_BITS  = 3;
   localparam logic [ROUTE_BITS-1:0] ROUTE_PARKED = 8'h80;
endpackage

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
   parameter int NUM_LINES = 4,
   parameter int LINE_W    = $clog2(NUM_LINES),
   parameter int SLOT_W    = 5,
   parameter int FN_W      = 3,
   parameter int SOLO_SLOT = 10,
   parameter int SOLO_LINE = 3,
   parameter int PAIR_LO   = 11,
   parameter int PAIR_HI   = 12,
   parameter int PAIR_LINE = 0,
   parameter int EXP_BASE  = 18,
   parameter int EXP_SLOTS = 4
) (
   input  logic [SLOT_W+FN_W-1:0] devfn,
   input  logic [LINE_W-1:0]      pin,
   output logic [LINE_W-1:0]      line
);
   localparam logic [SLOT_W-1:0] S_SOLO = SLOT_W'(SOLO_SLOT);
   localparam logic [SLOT_W-1:0] S_PLO  = SLOT_W'(PAIR_LO);
   localparam logic [SLOT_W-1:0] S_PHI  = SLOT_W'(PAIR_HI);
   localparam logic [SLOT_W-1:0] S_EXP  = SLOT_W'(EXP_BASE);
   localparam logic [SLOT_W-1:0] S_END  = SLOT_W'(EXP_BASE + EXP_SLOTS);
   localparam logic [LINE_W-1:0] L_SOLO = LINE_W'(SOLO_LINE);
   localparam logic [LINE_W-1:0] L_PAIR = LINE_W'(PAIR_LINE);

   if ((1 << LINE_W) != NUM_LINES) begin : g_bad_lines
      $error("irq_swizzle: NUM_LINES must be a power of two");
   end
   if (EXP_BASE + EXP_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("irq_swizzle: expansion slots exceed slot field");
   end

   logic [SLOT_W-1:0] slot;
   logic [SLOT_W-1:0] rel;

   assign slot = devfn[SLOT_W+FN_W-1:FN_W];
   assign rel  = slot - S_EXP;

   always_comb begin
      if (slot == S_SOLO)
         line = L_SOLO;
      else if (slot >= S_PLO && slot <= S_PHI)
         line = L_PAIR;
      else if (slot >= S_EXP && slot < S_END)
         line = rel[LINE_W-1:0] + pin;
      else
         line = pin;
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
   parameter int NUM_LINES = 4,
   parameter int LINE_W    = $clog2(NUM_LINES),
   parameter int ROUTE_W   = 8,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE = '1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [LINE_W-1:0]                 idx,
   input  logic [ROUTE_W-1:0]                data,
   output logic [NUM_LINES-1:0][ROUTE_W-1:0] route
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route[l] <= RESET_ROUTE;
         else if (we && idx == LINE_W'(l))
            route[l] <= data;
      end
   end
endmodule

// File: rtl/irq_or_matrix.sv
module irq_or_matrix #(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUT   = 16,
   parameter int ROUTE_W   = 8
) (
   input  logic [NUM_LINES-1:0][ROUTE_W-1:0] route,
   input  logic [NUM_LINES-1:0]              lvl,
   output logic [NUM_OUT-1:0]                out
);
   if (NUM_OUT > (1 << ROUTE_W)) begin : g_bad_out
      $error("irq_or_matrix: route field too narrow for NUM_OUT");
   end

   logic [NUM_OUT-1:0][NUM_LINES-1:0] hit;

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         // full-width compare: any value >= NUM_OUT matches no output
         assign hit[o][l] = lvl[l] && (route[l] == ROUTE_W'(o));
      end
      assign out[o] = |hit[o];
   end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
   parameter int NUM_LINES = irq_route_pkg::PCI_LINES,
   parameter int NUM_OUT   = irq_route_pkg::PIC_INPUTS,
   parameter int ROUTE_W   = irq_route_pkg::ROUTE_BITS,
   parameter int SLOT_W    = irq_route_pkg::SLOT_BITS,
   parameter int FN_W      = irq_route_pkg::FUNC_BITS,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE = irq_route_pkg::ROUTE_PARKED
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [SLOT_W+FN_W-1:0]          swz_devfn,
   input  logic [$clog2(NUM_LINES)-1:0]    swz_pin,
   output logic [$clog2(NUM_LINES)-1:0]    swz_line,
   input  logic                            cfg_we,
   input  logic [$clog2(NUM_LINES)-1:0]    cfg_idx,
   input  logic [ROUTE_W-1:0]              cfg_data,
   input  logic [NUM_LINES-1:0]            pci_lvl,
   output logic [NUM_OUT-1:0]              pic_lvl
);
   localparam int LINE_W = $clog2(NUM_LINES);

   if (RESET_ROUTE < NUM_OUT) begin : g_bad_reset
      $error("irq_route_top: reset route must leave lines disabled");
   end

   logic [NUM_LINES-1:0][ROUTE_W-1:0] route;

   irq_swizzle #(
      .NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
      .SLOT_W(SLOT_W), .FN_W(FN_W)
   ) u_swz (
      .devfn(swz_devfn), .pin(swz_pin), .line(swz_line)
   );

   irq_route_regs #(
      .NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
      .ROUTE_W(ROUTE_W), .RESET_ROUTE(RESET_ROUTE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
      .data(cfg_data), .route(route)
   );

   irq_or_matrix #(
      .NUM_LINES(NUM_LINES), .NUM_OUT(NUM_OUT), .ROUTE_W(ROUTE_W)
   ) u_or (
      .route(route), .lvl(pci_lvl), .out(pic_lvl)
   );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUT   = 16,
   parameter int ROUTE_W   = 8,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE = 8'h80
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [7:0]                   swz_devfn,
   input logic [1:0]                   swz_pin,
   input logic [1:0]                   swz_line,
   input logic                         cfg_we,
   input logic [$clog2(NUM_LINES)-1:0] cfg_idx,
   input logic [ROUTE_W-1:0]           cfg_data,
   input logic [NUM_LINES-1:0]         pci_lvl,
   input logic [NUM_OUT-1:0]           pic_lvl
);
   localparam int OUT_W = $clog2(NUM_OUT);

   logic [ROUTE_W-1:0] sh [NUM_LINES];
   logic [4:0]         slot;
   logic [NUM_OUT-1:0] want;
   logic               all_off;

   assign slot = swz_devfn[7:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LINES; l++) sh[l] <= RESET_ROUTE;
      end else if (cfg_we) begin
         sh[cfg_idx] <= cfg_data;
      end
   end

   always_comb begin
      want    = '0;
      all_off = 1'b1;
      for (int l = 0; l < NUM_LINES; l++) begin
         if (int'(sh[l]) < NUM_OUT) begin
            all_off = 1'b0;
            if (pci_lvl[l]) want[sh[l][OUT_W-1:0]] = 1'b1;
         end
      end
   end

   assert_solo_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == 5'd10) |-> (swz_line == 2'd3));
   assert_pair_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == 5'd11 || slot == 5'd12) |-> (swz_line == 2'd0));
   assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot >= 5'd18 && slot <= 5'd21) |-> (swz_line == 2'(slot[1:0] - 2'd2 + swz_pin)));
   assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot inside {5'd10, 5'd11, 5'd12, [5'd18:5'd21]}) |-> (swz_line == swz_pin));
   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_data) < NUM_OUT) |=>
         (!pci_lvl[$past(cfg_idx)] || pic_lvl[$past(cfg_data[OUT_W-1:0])]));
   assert_parked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> (pic_lvl == '0));
   assert_or_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pic_lvl == want);
endmodule

bind irq_route_top irq_route_chk #(
   .NUM_LINES(NUM_LINES), .NUM_OUT(NUM_OUT),
   .ROUTE_W(ROUTE_W), .RESET_ROUTE(RESET_ROUTE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .swz_devfn(swz_devfn), .swz_pin(swz_pin),
   .swz_line(swz_line), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
   .cfg_data(cfg_data), .pci_lvl(pci_lvl), .pic_lvl(pic_lvl)
);

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  swz_devfn = '0;
   logic [1:0]  swz_pin = '0;
   logic [1:0]  swz_line;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [7:0]  cfg_data = '0;
   logic [3:0]  pci_lvl = '0;
   logic [15:0] pic_lvl;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] mr [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_route_top u0 (
      .clk(clk), .rst_n(rst_n), .swz_devfn(swz_devfn), .swz_pin(swz_pin),
      .swz_line(swz_line), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .pci_lvl(pci_lvl), .pic_lvl(pic_lvl)
   );

   function automatic logic [1:0] exp_line(input logic [7:0] df, input logic [1:0] p);
      int s = int'(df[7:3]);
      if (s == 10) return 2'd3;
      if (s == 11 || s == 12) return 2'd0;
      if (s >= 18 && s <= 21) return 2'((s - 18 + int'(p)) % 4);
      return p;
   endfunction

   function automatic string slot_tag(input int s);
      if (s == 10) return "R1";
      if (s == 11 || s == 12) return "R2";
      if (s >= 18 && s <= 21) return "R3";
      return "R4";
   endfunction

   function automatic logic [15:0] exp_out(input logic [3:0] lv);
      logic [15:0] r = '0;
      for (int l = 0; l < 4; l++)
         if (int'(mr[l]) < 16 && lv[l]) r[mr[l][3:0]] = 1'b1;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: check settled state, drive new inputs, check same-cycle effect
   task automatic step(input string tag, input logic we, input logic [1:0] idx,
                       input logic [7:0] data, input logic [3:0] lv);
      @(negedge clk);
      chk(tag, 32'(pic_lvl), 32'(exp_out(pci_lvl)));
      cfg_we = we; cfg_idx = idx; cfg_data = data; pci_lvl = lv;
      #1;
      chk(tag, 32'(pic_lvl), 32'(exp_out(lv)));
      if (we) mr[idx] = data;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int l = 0; l < 4; l++) mr[l] = 8'h80;
      pci_lvl = 4'hf;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 in reset", 32'(pic_lvl), 32'h0);
      rst_n = 1'b1;

      // R5: parked after reset, all lines high
      step("R5", 1'b0, 2'd0, 8'h00, 4'hf);
      step("R5", 1'b0, 2'd0, 8'h00, 4'h5);
      // R6: route line0 to 5 (old route in same cycle, new after edge)
      step("R6", 1'b1, 2'd0, 8'd5, 4'h1);
      step("R6", 1'b0, 2'd0, 8'd0, 4'h1);
      @(negedge clk);
      chk("R6 route5", 32'(pic_lvl), 32'h0020);
      // R8: line1 shares output 5
      step("R8", 1'b1, 2'd1, 8'd5, 4'h3);
      step("R8", 1'b0, 2'd0, 8'd0, 4'h2);
      @(negedge clk);
      chk("R8 shared", 32'(pic_lvl), 32'h0020);
      step("R8", 1'b0, 2'd0, 8'd0, 4'h0);
      // R9: level change with no edge
      pci_lvl = 4'h2; #1;
      chk("R9 same cycle", 32'(pic_lvl), 32'h0020);
      // R7: boundary 16 and 255, then 15 enabled
      step("R7", 1'b1, 2'd2, 8'd16, 4'h4);
      step("R7", 1'b0, 2'd0, 8'd0, 4'h4);
      chk("R7 value16", 32'(pic_lvl), 32'h0);
      step("R7", 1'b1, 2'd2, 8'd255, 4'h4);
      step("R7", 1'b0, 2'd0, 8'd0, 4'h4);
      chk("R7 value255", 32'(pic_lvl), 32'h0);
      step("R7", 1'b1, 2'd2, 8'd15, 4'h4);
      step("R7", 1'b0, 2'd0, 8'd0, 4'h4);
      chk("R7 value15", 32'(pic_lvl), 32'h8000);
      step("R8", 1'b1, 2'd3, 8'd0, 4'h8);

      // swizzle: every slot and pin
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 4; p++) begin
            swz_devfn = {5'(s), 3'($urandom_range(0, 7))};
            swz_pin = 2'(p);
            #1;
            chk(slot_tag(s), 32'(swz_line), 32'(exp_line(swz_devfn, swz_pin)));
         end
      end

      // constrained random routes and levels
      for (int i = 0; i < 400; i++) begin
         logic [7:0] d;
         d = ($urandom_range(0, 3) != 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
         step("R8", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), d,
              4'($urandom_range(0, 15)));
         swz_devfn = 8'($urandom);
         swz_pin = 2'($urandom);
         #1;
         chk(slot_tag(int'(swz_devfn[7:3])), 32'(swz_line),
             32'(exp_line(swz_devfn, swz_pin)));
      end
      step("R8", 1'b0, 2'd0, 8'd0, 4'h0);
      @(negedge clk);
      chk("R8 final", 32'(pic_lvl), 32'(exp_out(pci_lvl)));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule